// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit

This unit sits at the front of a Viterbi decoder for a rate 1/2, constraint length 3 convolutional code. Each trellis step delivers two received code symbols, each quantized to a 3-bit soft level between 0 and 7. The unit compares that received pair with the ideal pair for each of the four possible branch words and returns all four distances in the same cycle. An add-compare-select array uses these distances directly.

An ideal code bit 0 sits at level 0 and an ideal code bit 1 sits at the top level, 7. The distance is the squared Euclidean distance. No square root is taken, because only the ordering of the metrics matters: a smaller metric marks a more likely branch. The four metrics and their valid flag are registered, so results appear one clock after the input valid flag. Between valid inputs, the outputs keep the last metrics they produced.

Top module: `sbm_branch_metrics`

## Requirements
- R1: While `rst_n` is low, at the next rising clock edge `out_valid` becomes 0 and all four metric outputs become 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge, so it is high exactly one cycle after each accepted input.
- R3: For branch word w (w1 w0), the metric is (a − 7·w1)² + (b − 7·w0)², where a is `sym_a` (the first code symbol) and b is `sym_b` (the second). `met_00`, `met_01`, `met_10` and `met_11` carry the metrics for w = 00, 01, 10 and 11.
- R4: The received pair (a=5, b=4) gives `met_00`=41, `met_01`=34, `met_10`=20 and `met_11`=13.
- R5: All four metrics of one input appear in the same output cycle, and none of them exceeds 98.
- R6: A cycle with `in_valid` low leaves all four metric outputs unchanged, whatever the symbol inputs carry.
- R7: When the received pair equals the ideal levels of a branch word, that word's metric is 0 and it is the only zero metric. The opposite word's metric is then 98.
- R8: For every accepted input, `met_00` + `met_11` equals `met_01` + `met_10`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A received symbol pair is present |
| sym_a | input | 3 | First received code symbol, soft level 0..7 |
| sym_b | input | 3 | Second received code symbol, soft level 0..7 |
| out_valid | output | 1 | The metric outputs hold a new result |
| met_00 | output | 8 | Metric against branch word 00 |
| met_01 | output | 8 | Metric against branch word 01 |
| met_10 | output | 8 | Metric against branch word 10 |
| met_11 | output | 8 | Metric against branch word 11 |

## Verification
All 64 received pairs are applied, and every one of the four metrics is compared with the closed-form squared distance. This sweep separates a swapped symbol-to-bit assignment, a wrong level for code bit 1, and a missing square. Because a=5, b=4 is not symmetric, the pair checks each word's bit order on its own. The four ideal corner pairs check the zero metric and the 98 extreme. Idle cycles with changing symbols show that the outputs hold, and gaps in `in_valid` show that `out_valid` follows with a one-cycle delay.

// File: rtl/sbm_pkg.sv
// Package sbm_pkg
// Shared widths and types for the soft-decision branch metric unit.
// Assumes two code symbols per trellis step (rate 1/2 code).
package sbm_pkg;

    // Soft-decision width of one received code symbol.
    parameter int SBM_SYM_W = 3;
    // Metric output width; must cover 2 * (2**SBM_SYM_W - 1)**2.
    parameter int SBM_MET_W = 8;
    // Number of code symbols per branch word.
    parameter int SBM_SYMS  = 2;

    localparam int SBM_WORDS = 1 << SBM_SYMS;
    localparam int SBM_SQ_W  = 2 * SBM_SYM_W;
    localparam int SBM_LVL   = (1 << SBM_SYM_W) - 1;
    localparam int SBM_MAX   = SBM_SYMS * SBM_LVL * SBM_LVL;

    typedef logic [SBM_SYM_W-1:0] sym_t;
    typedef logic [SBM_SQ_W-1:0]  sq_t;
    typedef logic [SBM_MET_W-1:0] met_t;

endpackage

// File: rtl/sbm_sym_terms.sv
// Module sbm_sym_terms
// Computes the two squared distances of one received soft symbol:
// to the level for code bit 0 (level 0) and to the level for code
// bit 1 (the top level). Assumes unsigned levels 0..2**W-1, so the
// distance to the top level is the bitwise complement of the symbol.
module sbm_sym_terms
    import sbm_pkg::*;
#(
    parameter int SYM_W = SBM_SYM_W,
    localparam int SQ_W = 2 * SYM_W
) (
    input  logic [SYM_W-1:0] sym,
    output logic [SQ_W-1:0]  sq_to_zero,
    output logic [SQ_W-1:0]  sq_to_one
);

    logic [SQ_W-1:0] dist_zero;
    logic [SQ_W-1:0] dist_one;

    // Zero-extend both distances to the square width.
    always_comb begin
        dist_zero = {{SYM_W{1'b0}}, sym};
        dist_one  = {{SYM_W{1'b0}}, ~sym};
    end

    // Square each distance; the product fits exactly in SQ_W bits.
    always_comb begin
        sq_to_zero = dist_zero * dist_zero;
        sq_to_one  = dist_one * dist_one;
    end

endmodule

// File: rtl/sbm_word_adder.sv
// Module sbm_word_adder
// Forms the metric of one fixed branch word by picking, for each
// code symbol, the squared term matching that word's bit and adding
// the picks. WORD bit 1 pairs with the first symbol, bit 0 with the
// second. Assumes MET_W holds the sum of two SQ_W-bit squares.
module sbm_word_adder
    import sbm_pkg::*;
#(
    parameter int WORD  = 0,
    parameter int SQ_W  = SBM_SQ_W,
    parameter int MET_W = SBM_MET_W
) (
    input  logic [SQ_W-1:0]  a_sq_zero,
    input  logic [SQ_W-1:0]  a_sq_one,
    input  logic [SQ_W-1:0]  b_sq_zero,
    input  logic [SQ_W-1:0]  b_sq_one,
    output logic [MET_W-1:0] metric
);

    localparam bit BIT_A = WORD[1];
    localparam bit BIT_B = WORD[0];

    logic [SQ_W-1:0] term_a;
    logic [SQ_W-1:0] term_b;

    // Select the term for each symbol from the fixed word bits.
    generate
        if (BIT_A) begin : g_a_one
            always_comb term_a = a_sq_one;
        end else begin : g_a_zero
            always_comb term_a = a_sq_zero;
        end
        if (BIT_B) begin : g_b_one
            always_comb term_b = b_sq_one;
        end else begin : g_b_zero
            always_comb term_b = b_sq_zero;
        end
    endgenerate

    // Add the two terms at metric width.
    always_comb begin
        metric = MET_W'(term_a) + MET_W'(term_b);
    end

endmodule

// File: rtl/sbm_branch_metrics.sv
// Module sbm_branch_metrics (top)
// Soft-decision branch metric unit for a rate 1/2 code. For every
// valid received pair it outputs, one cycle later, the squared
// Euclidean distance to each of the four ideal branch words.
// Assumes synchronous active-low reset. The outputs hold their
// value between valid inputs.
module sbm_branch_metrics
    import sbm_pkg::*;
#(
    parameter int SYM_W = SBM_SYM_W,
    parameter int MET_W = SBM_MET_W,
    localparam int SQ_W  = 2 * SYM_W,
    localparam int WORDS = SBM_WORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] sym_a,
    input  logic [SYM_W-1:0] sym_b,
    output logic             out_valid,
    output logic [MET_W-1:0] met_00,
    output logic [MET_W-1:0] met_01,
    output logic [MET_W-1:0] met_10,
    output logic [MET_W-1:0] met_11
);

    logic [SQ_W-1:0]  a_sq_zero, a_sq_one;
    logic [SQ_W-1:0]  b_sq_zero, b_sq_one;
    logic [MET_W-1:0] met_next [WORDS];
    logic [MET_W-1:0] met_q    [WORDS];
    logic             valid_q;

    // Shared squared terms for the first symbol.
    sbm_sym_terms #(.SYM_W(SYM_W)) u_terms_a (
        .sym        (sym_a),
        .sq_to_zero (a_sq_zero),
        .sq_to_one  (a_sq_one)
    );

    // Shared squared terms for the second symbol.
    sbm_sym_terms #(.SYM_W(SYM_W)) u_terms_b (
        .sym        (sym_b),
        .sq_to_zero (b_sq_zero),
        .sq_to_one  (b_sq_one)
    );

    // One adder per branch word, all working in parallel.
    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            sbm_word_adder #(
                .WORD  (w),
                .SQ_W  (SQ_W),
                .MET_W (MET_W)
            ) u_add (
                .a_sq_zero (a_sq_zero),
                .a_sq_one  (a_sq_one),
                .b_sq_zero (b_sq_zero),
                .b_sq_one  (b_sq_one),
                .metric    (met_next[w])
            );
        end
    endgenerate

    // Valid flag pipeline: one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= in_valid;
    end

    // Metric registers: load on valid input, hold otherwise.
    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n)        met_q[w] <= '0;
                else if (in_valid) met_q[w] <= met_next[w];
            end
        end
    endgenerate

    // Drive the named output ports from the register array.
    always_comb begin
        out_valid = valid_q;
        met_00    = met_q[0];
        met_01    = met_q[1];
        met_10    = met_q[2];
        met_11    = met_q[3];
    end

endmodule

// File: rtl/sbm_branch_metrics_chk.sv
// Module sbm_branch_metrics_chk
// Property checker bound to sbm_branch_metrics. It observes ports only.
module sbm_branch_metrics_chk #(
    parameter int SYM_W = 3,
    parameter int MET_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [SYM_W-1:0] sym_a,
    input logic [SYM_W-1:0] sym_b,
    input logic             out_valid,
    input logic [MET_W-1:0] met_00,
    input logic [MET_W-1:0] met_01,
    input logic [MET_W-1:0] met_10,
    input logic [MET_W-1:0] met_11
);

    localparam int LVL  = (1 << SYM_W) - 1;
    localparam int MMAX = 2 * LVL * LVL;

    // Closed-form squared distance to word w.
    function automatic int ref_met(input int a, input int b, input int w);
        int da, db;
        da = ((w >> 1) & 1) ? (LVL - a) : a;
        db = (w & 1) ? (LVL - b) : b;
        return da * da + db * db;
    endfunction

    // R1: reset clears the valid flag and all metrics.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && met_00 == 0 && met_01 == 0 &&
                    met_10 == 0 && met_11 == 0));

    // R2: the valid flag follows the input flag by one cycle.
    p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: each metric matches the squared distance of the sampled pair.
    p_metric_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=>
            (int'(met_00) == ref_met(int'($past(sym_a)), int'($past(sym_b)), 0) &&
             int'(met_01) == ref_met(int'($past(sym_a)), int'($past(sym_b)), 1) &&
             int'(met_10) == ref_met(int'($past(sym_a)), int'($past(sym_b)), 2) &&
             int'(met_11) == ref_met(int'($past(sym_a)), int'($past(sym_b)), 3)));

    // R5: no metric exceeds the largest possible distance.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(met_00) <= MMAX && int'(met_01) <= MMAX &&
                       int'(met_10) <= MMAX && int'(met_11) <= MMAX));

    // R6: idle cycles leave the metrics unchanged.
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(met_00) && $stable(met_01) &&
                       $stable(met_10) && $stable(met_11)));

    // R8: the opposite-word sums agree.
    p_pair_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(met_00) + int'(met_11) == int'(met_01) + int'(met_10)));

endmodule

bind sbm_branch_metrics sbm_branch_metrics_chk #(
    .SYM_W (SYM_W),
    .MET_W (MET_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sym_a     (sym_a),
    .sym_b     (sym_b),
    .out_valid (out_valid),
    .met_00    (met_00),
    .met_01    (met_01),
    .met_10    (met_10),
    .met_11    (met_11)
);

// File: tb/sbm_branch_metrics_tb.sv
// Bench for sbm_branch_metrics: exhaustive sweep of all received pairs.
module sbm_branch_metrics_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] sym_a = '0;
    logic [2:0] sym_b = '0;
    logic       out_valid;
    logic [7:0] met_00, met_01, met_10, met_11;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    sbm_branch_metrics u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sym_a     (sym_a),
        .sym_b     (sym_b),
        .out_valid (out_valid),
        .met_00    (met_00),
        .met_01    (met_01),
        .met_10    (met_10),
        .met_11    (met_11)
    );

    function automatic int model(input int a, input int b, input int w);
        int da, db;
        da = w[1] ? (7 - a) : a;
        db = w[0] ? (7 - b) : b;
        return da * da + db * db;
    endfunction

    function automatic int out_met(input int w);
        case (w)
            0:       return int'(met_00);
            1:       return int'(met_01);
            2:       return int'(met_10);
            default: return int'(met_11);
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one valid pair at a falling edge; results are checked at the next one.
    task automatic apply(input int a, input int b);
        @(negedge clk);
        in_valid = 1'b1;
        sym_a    = 3'(a);
        sym_b    = 3'(b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", int'(out_valid), 0);
        for (int w = 0; w < 4; w++) check("R1 metric", out_met(w), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle out_valid", int'(out_valid), 0);

        // R4: named pair
        apply(5, 4);
        check("R4 met_00", int'(met_00), 41);
        check("R4 met_01", int'(met_01), 34);
        check("R4 met_10", int'(met_10), 20);
        check("R4 met_11", int'(met_11), 13);
        check("R2 valid one cycle later", int'(out_valid), 1);

        // R6: idle with changing symbols keeps metrics
        sym_a = 3'd0; sym_b = 3'd7;
        @(negedge clk);
        check("R2 low after idle", int'(out_valid), 0);
        check("R6 hold met_00", int'(met_00), 41);
        check("R6 hold met_01", int'(met_01), 34);
        check("R6 hold met_10", int'(met_10), 20);
        check("R6 hold met_11", int'(met_11), 13);

        // R3, R5, R8: exhaustive sweep, back-to-back inputs
        for (int p = 0; p < 64; p++) begin
            @(negedge clk);
            if (p > 0) begin
                for (int w = 0; w < 4; w++)
                    check("R3 sweep", out_met(w), model((p-1) >> 3, (p-1) & 7, w));
                check("R5 same-cycle valid", int'(out_valid), 1);
                check("R8 pair sum", int'(met_00) + int'(met_11),
                      int'(met_01) + int'(met_10));
            end
            in_valid = 1'b1;
            sym_a = 3'(p >> 3);
            sym_b = 3'(p & 7);
        end
        @(negedge clk);
        in_valid = 1'b0;
        for (int w = 0; w < 4; w++) check("R3 sweep last", out_met(w), model(7, 7, w));
        check("R5 max 98", int'(met_00), 98);

        // R7: ideal corner pairs
        for (int c = 0; c < 4; c++) begin
            apply(c[1] ? 7 : 0, c[0] ? 7 : 0);
            for (int w = 0; w < 4; w++) begin
                if (w == c)          check("R7 match zero", out_met(w), 0);
                else if (w == 3 - c) check("R7 opposite 98", out_met(w), 98);
                else                 check("R7 other nonzero", int'(out_met(w) != 0), 1);
            end
        end

        // R1: reset again after activity
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset met_11", int'(met_11), 0);
        check("R1 re-reset out_valid", int'(out_valid), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule